// File: doc/BRIEF.md
# DDR2 Command Decoder and Tracker

This block observes the control pins of a DDR2 command bus on every rising clock edge. It names the command of each cycle and registers that name together with the target bank and the address field that matters for it. A second CKE register lets the decoder tell ordinary commands apart from entries to and exits from power-down and self-refresh. The block is a passive monitor: it drives nothing onto the bus. Its outputs go to a controller's checking logic or to a protocol scoreboard.

Besides decoding, the block tracks state. It holds the device mode (active, power-down, self-refresh) and keeps one open-row record for each bank. It runs a burst window that follows the programmed burst length, which is 4 or 8. A one-cycle violation pulse marks any command that breaks the sequencing rules. A warning output goes high when the device has stayed in power-down longer than a limit set at a port. Electrical timing, termination and the data path are not modelled.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: Each rising edge decodes the pins. The result appears on `cmd_o` after that same edge, and `bank_o` carries the sampled BA. Command codes: 0 deselect, 1 no-op, 2 mode load, 3 refresh, 4 self-refresh entry, 5 self-refresh exit, 6 precharge one bank, 7 precharge all, 8 activate, 9 write, 10 write with auto precharge, 11 read, 12 read with auto precharge, 13 power-down entry, 14 CKE wake, 15 CKE held low, 16 illegal. When CKE is high on both the previous and the current edge, CS# high decodes as deselect. With CS# low, the pins {RAS#,CAS#,WE#} decode as 000 mode load, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read and 111 no-op.
- R2: CKE high then low enters a low-power state. With the refresh pin pattern, the result is code 4 and `dev_state_o` becomes 2 (self-refresh). With no-op or deselect, the result is code 13 and `dev_state_o` becomes 1 (power-down). Any other pattern gives code 16 with a violation, and `dev_state_o` stays at 0 (active).
- R3: In self-refresh, the first edge that samples CKE high gives code 5 and returns `dev_state_o` to 0 with no violation, whatever the other pins show.
- R4: CKE low on both edges gives code 15 and leaves the state unchanged. CKE low then high outside self-refresh gives code 14 and returns `dev_state_o` to 0. That edge raises a violation unless the pins show no-op or deselect.
- R5: For a precharge, A10 high means all banks (code 7) and closes every open row. A10 low means the single bank on BA (code 6).
- R6: For a read or write, A10 high selects the auto-precharge code (10 or 12) and closes that bank's row. `addr_o` holds the column {A[ADDR_W-1:11], A[9:0]} with a zero on top. `open_row_o` holds the row recorded for that bank. For an activate or mode load, `addr_o` holds the full address.
- R7: An accepted read or write opens a burst window of BL/2-1 further edges, shown on `burst_busy_o`. On those edges, any read, write or precharge-all is a violation, as is a single-bank precharge to the bursting bank. A precharge to a different bank is allowed.
- R8: An activate to a bank whose row is open, and a read or write to a bank with no open row, are violations.
- R9: A command flagged as a violation changes no bank record, no burst window and no burst length.
- R10: A counter clears on power-down entry and counts each later edge spent in power-down. `refresh_warn_o` is high while in power-down with the count above `pd_limit`. The count is zero outside power-down.
- R11: `bl8_o` (0 = burst of 4, 1 = burst of 8) changes only on a mode load with BA = 0. A[2:0] = 010 selects 4 and 011 selects 8. Any other value leaves it unchanged, and so does a mode load to any other BA.
- R12: The pattern CS# low with {RAS#,CAS#,WE#} = 110 gives code 16 with a violation.
- R13: Reset gives code 0, state 0, burst length 4, all banks closed, and no burst, violation or warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address bus (A10 is the precharge qualifier) |
| pd_limit | input | PD_W | Power-down edge limit before warning |
| cmd_o | output | 5 | Decoded command code |
| bank_o | output | BA_W | Sampled bank address |
| addr_o | output | ADDR_W | Row, column or opcode per command |
| open_row_o | output | ADDR_W | Recorded row of the bank hit by a read or write |
| viol_o | output | 1 | Sequencing violation pulse |
| dev_state_o | output | 2 | 0 active, 1 power-down, 2 self-refresh |
| burst_busy_o | output | 1 | Burst window open |
| bl8_o | output | 1 | Burst length is 8 |
| refresh_warn_o | output | 1 | Power-down has lasted longer than the limit |

## Verification
The assertions check four things on every cycle. Any read, write or precharge-all that lands in an open burst window must be flagged. A burst window may open only on an accepted read or write. The low-power state must follow the entry and exit codes. The burst length may move only on a mode load to register 0. The bench scenarios cover what needs a history of commands. These are the open-row bookkeeping, the closing of a row by auto precharge, and the exact length of the 4- and 8-beat windows. They also include the rule that a flagged command leaves every record unchanged, the column mapping, and the edge on which the power-down warning first rises.

// File: rtl/ddr2_trk_pkg.sv
package ddr2_trk_pkg;

    typedef enum logic [4:0] {
        CMD_DESEL   = 5'd0,
        CMD_NOP     = 5'd1,
        CMD_MODE    = 5'd2,
        CMD_REF     = 5'd3,
        CMD_SR_IN   = 5'd4,
        CMD_SR_OUT  = 5'd5,
        CMD_PRE_ONE = 5'd6,
        CMD_PRE_ALL = 5'd7,
        CMD_ACT     = 5'd8,
        CMD_WR      = 5'd9,
        CMD_WR_AP   = 5'd10,
        CMD_RD      = 5'd11,
        CMD_RD_AP   = 5'd12,
        CMD_PD_IN   = 5'd13,
        CMD_PD_OUT  = 5'd14,
        CMD_HOLD    = 5'd15,
        CMD_BAD     = 5'd16
    } cmd_e;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PWRDN   = 2'd1,
        ST_SELFREF = 2'd2
    } dev_state_e;

    // Mode-register burst-length field values
    localparam logic [2:0] BL_FIELD_4 = 3'b010;
    localparam logic [2:0] BL_FIELD_8 = 3'b011;

endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
    import ddr2_trk_pkg::*;
(
    input  logic       cke_prev,
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       a10,
    input  dev_state_e state,
    output cmd_e       cmd,
    output logic       pin_bad
);

    logic idle;
    logic ref_pat;

    always_comb begin
        idle    = cs_n | (ras_n & cas_n & we_n);
        ref_pat = !cs_n && !ras_n && !cas_n && we_n;
        cmd     = CMD_HOLD;
        pin_bad = 1'b0;
        case ({cke_prev, cke})
            2'b11: begin
                if (cs_n) begin
                    cmd = CMD_DESEL;
                end else begin
                    case ({ras_n, cas_n, we_n})
                        3'b000:  cmd = CMD_MODE;
                        3'b001:  cmd = CMD_REF;
                        3'b010:  cmd = a10 ? CMD_PRE_ALL : CMD_PRE_ONE;
                        3'b011:  cmd = CMD_ACT;
                        3'b100:  cmd = a10 ? CMD_WR_AP : CMD_WR;
                        3'b101:  cmd = a10 ? CMD_RD_AP : CMD_RD;
                        3'b111:  cmd = CMD_NOP;
                        default: begin
                            cmd     = CMD_BAD;
                            pin_bad = 1'b1;
                        end
                    endcase
                end
            end
            2'b10: begin
                if (ref_pat) begin
                    cmd = CMD_SR_IN;
                end else if (idle) begin
                    cmd = CMD_PD_IN;
                end else begin
                    cmd     = CMD_BAD;
                    pin_bad = 1'b1;
                end
            end
            2'b01: begin
                if (state == ST_SELFREF) begin
                    // leaving self-refresh needs no valid command
                    cmd = CMD_SR_OUT;
                end else begin
                    cmd     = CMD_PD_OUT;
                    pin_bad = !idle;
                end
            end
            default: cmd = CMD_HOLD;
        endcase
    end

endmodule

// File: rtl/ddr2_bank_table.sv
module ddr2_bank_table #(
    parameter int BA_W  = 3,
    parameter int ROW_W = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  act_en,
    input  logic                  close_one_en,
    input  logic                  close_all_en,
    input  logic [BA_W-1:0]       bank_sel,
    input  logic [ROW_W-1:0]      act_row,
    output logic [(1<<BA_W)-1:0]  open_vec,
    output logic [ROW_W-1:0]      sel_row
);

    localparam int NBANK = 1 << BA_W;

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } bank_t;

    logic [ROW_W-1:0] row_arr [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        bank_t b_d;
        bank_t b_q;
        logic  hit;

        always_comb begin
            hit = (bank_sel == BA_W'(g));
            b_d = b_q;
            if (close_all_en || (close_one_en && hit)) begin
                b_d.open = 1'b0;
            end
            if (act_en && hit) begin
                b_d.open = 1'b1;
                b_d.row  = act_row;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                b_q <= '0;
            end else begin
                b_q <= b_d;
            end
        end

        assign open_vec[g] = b_q.open;
        assign row_arr[g]  = b_q.row;
    end

    assign sel_row = row_arr[bank_sel];

endmodule

// File: rtl/ddr2_burst_timer.sv
module ddr2_burst_timer #(
    parameter int BA_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            bl8,
    input  logic [BA_W-1:0] start_bank,
    output logic            busy,
    output logic [BA_W-1:0] bank
);

    localparam int BL_MAX   = 8;
    localparam int BL_MIN   = 4;
    localparam int CNT_W    = $clog2(BL_MAX / 2);
    localparam int LOAD_MAX = BL_MAX / 2 - 1;
    localparam int LOAD_MIN = BL_MIN / 2 - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [BA_W-1:0]  bank;
    } tmr_t;

    tmr_t t_d;
    tmr_t t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.cnt  = bl8 ? CNT_W'(LOAD_MAX) : CNT_W'(LOAD_MIN);
            t_d.bank = start_bank;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy = (t_q.cnt != '0);
    assign bank = t_q.bank;

endmodule

// File: rtl/ddr2_cmd_tracker.sv
module ddr2_cmd_tracker
    import ddr2_trk_pkg::*;
#(
    parameter int BA_W   = 3,
    parameter int ADDR_W = 13,   // at least 12: A10 plus column bits around it
    parameter int PD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PD_W-1:0]   pd_limit,
    output logic [4:0]        cmd_o,
    output logic [BA_W-1:0]   bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] open_row_o,
    output logic              viol_o,
    output logic [1:0]        dev_state_o,
    output logic              burst_busy_o,
    output logic              bl8_o,
    output logic              refresh_warn_o
);

    localparam int NBANK = 1 << BA_W;
    localparam int COL_W = ADDR_W - 1;
    localparam int AP_BIT = 10;

    typedef struct packed {
        logic              cke_prev;
        dev_state_e        state;
        logic [PD_W-1:0]   pd_cnt;
        logic              bl8;
        cmd_e              cmd;
        logic [BA_W-1:0]   bank;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] open_row;
        logic              viol;
    } trk_t;

    trk_t s_d;
    trk_t s_q;

    cmd_e              dec_cmd;
    logic              pin_bad;
    logic [NBANK-1:0]  open_vec;
    logic [ADDR_W-1:0] sel_row;
    logic              busy;
    logic [BA_W-1:0]   busy_bank;
    logic [COL_W-1:0]  col;
    logic              is_col;
    logic              v_burst;
    logic              v_bank;
    logic              viol;
    logic              ok;
    logic              act_en;
    logic              close_one_en;
    logic              close_all_en;
    logic              burst_start;

    ddr2_cmd_decode i_decode (
        .cke_prev (s_q.cke_prev),
        .cke      (cke),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .a10      (addr[AP_BIT]),
        .state    (s_q.state),
        .cmd      (dec_cmd),
        .pin_bad  (pin_bad)
    );

    ddr2_bank_table #(.BA_W(BA_W), .ROW_W(ADDR_W)) i_banks (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_en       (act_en),
        .close_one_en (close_one_en),
        .close_all_en (close_all_en),
        .bank_sel     (ba),
        .act_row      (addr),
        .open_vec     (open_vec),
        .sel_row      (sel_row)
    );

    ddr2_burst_timer #(.BA_W(BA_W)) i_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (burst_start),
        .bl8        (s_q.bl8),
        .start_bank (ba),
        .busy       (busy),
        .bank       (busy_bank)
    );

    always_comb begin
        col    = {addr[ADDR_W-1:AP_BIT+1], addr[AP_BIT-1:0]};
        is_col = (dec_cmd == CMD_RD) || (dec_cmd == CMD_RD_AP) ||
                 (dec_cmd == CMD_WR) || (dec_cmd == CMD_WR_AP);

        v_burst = busy && (is_col || (dec_cmd == CMD_PRE_ALL) ||
                           ((dec_cmd == CMD_PRE_ONE) && (ba == busy_bank)));
        v_bank  = (is_col && !open_vec[ba]) ||
                  ((dec_cmd == CMD_ACT) && open_vec[ba]);
        viol    = pin_bad || v_burst || v_bank;
        ok      = !viol;

        act_en       = ok && (dec_cmd == CMD_ACT);
        close_one_en = ok && ((dec_cmd == CMD_PRE_ONE) || (dec_cmd == CMD_RD_AP) ||
                              (dec_cmd == CMD_WR_AP));
        close_all_en = ok && (dec_cmd == CMD_PRE_ALL);
        burst_start  = ok && is_col;

        s_d          = s_q;
        s_d.cke_prev = cke;
        s_d.cmd      = dec_cmd;
        s_d.bank     = ba;
        s_d.viol     = viol;

        if (is_col) begin
            s_d.addr     = {1'b0, col};
            s_d.open_row = sel_row;
        end else begin
            s_d.addr     = ((dec_cmd == CMD_ACT) || (dec_cmd == CMD_MODE)) ? addr : '0;
            s_d.open_row = '0;
        end

        if (ok && (dec_cmd == CMD_MODE) && (ba == '0)) begin
            if (addr[2:0] == BL_FIELD_8) begin
                s_d.bl8 = 1'b1;
            end else if (addr[2:0] == BL_FIELD_4) begin
                s_d.bl8 = 1'b0;
            end
        end

        case (dec_cmd)
            CMD_SR_IN:             s_d.state = ST_SELFREF;
            CMD_PD_IN:             s_d.state = ST_PWRDN;
            CMD_SR_OUT, CMD_PD_OUT: s_d.state = ST_ACTIVE;
            default:               s_d.state = s_q.state;
        endcase

        if ((s_d.state == ST_PWRDN) && (s_q.state == ST_PWRDN)) begin
            s_d.pd_cnt = (s_q.pd_cnt == '1) ? s_q.pd_cnt : s_q.pd_cnt + 1'b1;
        end else begin
            s_d.pd_cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.cke_prev <= 1'b1;
            s_q.state    <= ST_ACTIVE;
            s_q.cmd      <= CMD_DESEL;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_o          = s_q.cmd;
    assign bank_o         = s_q.bank;
    assign addr_o         = s_q.addr;
    assign open_row_o     = s_q.open_row;
    assign viol_o         = s_q.viol;
    assign dev_state_o    = s_q.state;
    assign burst_busy_o   = busy;
    assign bl8_o          = s_q.bl8;
    assign refresh_warn_o = (s_q.state == ST_PWRDN) && (s_q.pd_cnt > pd_limit);

endmodule

// File: rtl/ddr2_cmd_tracker_chk.sv
module ddr2_cmd_tracker_chk
    import ddr2_trk_pkg::*;
#(
    parameter int BA_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      cmd_o,
    input logic [BA_W-1:0] bank_o,
    input logic            viol_o,
    input logic [1:0]      dev_state_o,
    input logic            burst_busy_o,
    input logic            bl8_o,
    input logic            refresh_warn_o
);

    logic col_or_all;
    logic col_cmd;

    always_comb begin
        col_cmd    = (cmd_o == CMD_RD) || (cmd_o == CMD_RD_AP) ||
                     (cmd_o == CMD_WR) || (cmd_o == CMD_WR_AP);
        col_or_all = col_cmd || (cmd_o == CMD_PRE_ALL);
    end

    // R7
    burst_interrupt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_or_all && $past(burst_busy_o)) |-> viol_o);

    // R7
    burst_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_busy_o) |-> (col_cmd && !viol_o));

    // R2
    sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_SR_IN) |-> (dev_state_o == ST_SELFREF));

    // R3
    sr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(dev_state_o) == ST_SELFREF) && (dev_state_o != ST_SELFREF))
        |-> ((cmd_o == CMD_SR_OUT) && !viol_o));

    // R4
    wake_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PD_OUT) |-> (dev_state_o == ST_ACTIVE));

    // R10
    warn_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_warn_o) |-> ($past(dev_state_o) == ST_PWRDN));

    // R11
    bl_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bl8_o) |-> ((cmd_o == CMD_MODE) && (bank_o == '0)));

endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(.BA_W(BA_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_o          (cmd_o),
    .bank_o         (bank_o),
    .viol_o         (viol_o),
    .dev_state_o    (dev_state_o),
    .burst_busy_o   (burst_busy_o),
    .bl8_o          (bl8_o),
    .refresh_warn_o (refresh_warn_o)
);

// File: tb/test_ddr2_cmd_tracker.sv
module test_ddr2_cmd_tracker;

    localparam int BA_W   = 3;
    localparam int ADDR_W = 13;
    localparam int PD_W   = 16;

    // pin patterns {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] P_NOP  = 4'b0111;
    localparam logic [3:0] P_DES  = 4'b1111;
    localparam logic [3:0] P_MODE = 4'b0000;
    localparam logic [3:0] P_REF  = 4'b0001;
    localparam logic [3:0] P_PRE  = 4'b0010;
    localparam logic [3:0] P_ACT  = 4'b0011;
    localparam logic [3:0] P_WR   = 4'b0100;
    localparam logic [3:0] P_RD   = 4'b0101;
    localparam logic [3:0] P_RSV  = 4'b0110;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cke = 1'b1;
    logic              cs_n = 1'b0;
    logic              ras_n = 1'b1;
    logic              cas_n = 1'b1;
    logic              we_n = 1'b1;
    logic [BA_W-1:0]   ba = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [PD_W-1:0]   pd_limit = 16'd5;
    logic [4:0]        cmd_o;
    logic [BA_W-1:0]   bank_o;
    logic [ADDR_W-1:0] addr_o;
    logic [ADDR_W-1:0] open_row_o;
    logic              viol_o;
    logic [1:0]        dev_state_o;
    logic              burst_busy_o;
    logic              bl8_o;
    logic              refresh_warn_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ddr2_cmd_tracker #(.BA_W(BA_W), .ADDR_W(ADDR_W), .PD_W(PD_W)) i_ddr2_cmd_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .cke            (cke),
        .cs_n           (cs_n),
        .ras_n          (ras_n),
        .cas_n          (cas_n),
        .we_n           (we_n),
        .ba             (ba),
        .addr           (addr),
        .pd_limit       (pd_limit),
        .cmd_o          (cmd_o),
        .bank_o         (bank_o),
        .addr_o         (addr_o),
        .open_row_o     (open_row_o),
        .viol_o         (viol_o),
        .dev_state_o    (dev_state_o),
        .burst_busy_o   (burst_busy_o),
        .bl8_o          (bl8_o),
        .refresh_warn_o (refresh_warn_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive pins just after a falling edge; return at the next falling edge,
    // when the outputs show the result of the rising edge in between.
    task automatic drive(input logic k, input logic [3:0] p,
                         input logic [BA_W-1:0] b, input logic [ADDR_W-1:0] a);
        cke = k;
        {cs_n, ras_n, cas_n, we_n} = p;
        ba = b;
        addr = a;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R13 cmd", int'(cmd_o), 0);
        check("R13 state", int'(dev_state_o), 0);
        check("R13 viol", int'(viol_o), 0);
        check("R13 busy", int'(burst_busy_o), 0);
        check("R13 bl8", int'(bl8_o), 0);
        check("R13 warn", int'(refresh_warn_o), 0);
    endtask

    task automatic t_decode;
        drive(1, P_NOP, 0, 0);
        check("R1 nop", int'(cmd_o), 1);
        drive(1, P_DES, 0, 0);
        check("R1 deselect", int'(cmd_o), 0);
        drive(1, P_MODE, 1, 13'h0443);
        check("R1 mode code", int'(cmd_o), 2);
        check("R1 mode bank", int'(bank_o), 1);
        check("R6 mode addr", int'(addr_o), 'h0443);
        check("R11 other register", int'(bl8_o), 0);
        drive(1, P_REF, 0, 0);
        check("R1 refresh", int'(cmd_o), 3);
        check("R1 refresh ok", int'(viol_o), 0);
        drive(1, P_RSV, 0, 0);
        check("R12 code", int'(cmd_o), 16);
        check("R12 viol", int'(viol_o), 1);
        drive(1, P_NOP, 0, 0);
        check("R1 viol clears", int'(viol_o), 0);
    endtask

    task automatic t_bank;
        drive(1, P_ACT, 2, 13'h0155);
        check("R8 act code", int'(cmd_o), 8);
        check("R6 act addr", int'(addr_o), 'h0155);
        check("R8 act ok", int'(viol_o), 0);
        drive(1, P_ACT, 2, 13'h00AA);
        check("R8 act open", int'(viol_o), 1);
        drive(1, P_RD, 2, 13'h0805);
        check("R1 read code", int'(cmd_o), 11);
        check("R6 column", int'(addr_o), 'h0405);
        check("R9 row kept", int'(open_row_o), 'h0155);
        check("R8 read ok", int'(viol_o), 0);
        check("R7 busy", int'(burst_busy_o), 1);
        drive(1, P_NOP, 0, 0);
        check("R7 bl4 end", int'(burst_busy_o), 0);
        drive(1, P_RD, 5, 0);
        check("R8 read closed", int'(viol_o), 1);
        check("R9 no burst", int'(burst_busy_o), 0);
        drive(1, P_RD, 2, 13'h0400);
        check("R6 read ap code", int'(cmd_o), 12);
        check("R6 read ap ok", int'(viol_o), 0);
        drive(1, P_NOP, 0, 0);
        drive(1, P_RD, 2, 0);
        check("R6 ap closed row", int'(viol_o), 1);
        drive(1, P_WR, 2, 13'h0400);
        check("R6 write ap code", int'(cmd_o), 10);
        drive(1, P_NOP, 0, 0);
    endtask

    task automatic t_burst;
        drive(1, P_ACT, 1, 13'h0010);
        drive(1, P_RD, 1, 0);
        check("R7 rd ok", int'(viol_o), 0);
        drive(1, P_WR, 1, 0);
        check("R1 write code", int'(cmd_o), 9);
        check("R7 bl4 interrupt", int'(viol_o), 1);
        drive(1, P_RD, 1, 0);
        check("R7 bl4 after window", int'(viol_o), 0);
        drive(1, P_PRE, 1, 0);
        check("R5 pre one code", int'(cmd_o), 6);
        check("R7 pre same bank", int'(viol_o), 1);
        drive(1, P_NOP, 0, 0);
        drive(1, P_ACT, 3, 13'h0020);
        drive(1, P_RD, 1, 0);
        drive(1, P_PRE, 3, 0);
        check("R7 pre other bank", int'(viol_o), 0);
        drive(1, P_NOP, 0, 0);
        drive(1, P_MODE, 0, 13'h0003);
        check("R11 bl8 set", int'(bl8_o), 1);
        drive(1, P_WR, 1, 0);
        check("R7 bl8 start", int'(viol_o), 0);
        drive(1, P_NOP, 0, 0);
        drive(1, P_NOP, 0, 0);
        check("R7 bl8 busy", int'(burst_busy_o), 1);
        drive(1, P_RD, 1, 0);
        check("R7 bl8 interrupt", int'(viol_o), 1);
        drive(1, P_RD, 1, 0);
        check("R7 bl8 after window", int'(viol_o), 0);
        drive(1, P_NOP, 0, 0);
        drive(1, P_NOP, 0, 0);
        drive(1, P_NOP, 0, 0);
        check("R7 bl8 end", int'(burst_busy_o), 0);
        drive(1, P_MODE, 1, 13'h0002);
        check("R11 bank1 ignored", int'(bl8_o), 1);
        drive(1, P_MODE, 0, 13'h0005);
        check("R11 field ignored", int'(bl8_o), 1);
        drive(1, P_MODE, 0, 13'h0002);
        check("R11 bl4 set", int'(bl8_o), 0);
        drive(1, P_PRE, 0, 13'h0400);
        check("R5 pre all code", int'(cmd_o), 7);
        check("R5 pre all ok", int'(viol_o), 0);
        drive(1, P_RD, 1, 0);
        check("R5 all closed", int'(viol_o), 1);
        drive(1, P_NOP, 0, 0);
    endtask

    task automatic t_powerdown;
        drive(0, P_NOP, 0, 0);
        check("R2 pd code", int'(cmd_o), 13);
        check("R2 pd state", int'(dev_state_o), 1);
        for (int i = 0; i < 5; i++) drive(0, P_NOP, 0, 0);
        check("R4 hold code", int'(cmd_o), 15);
        check("R10 at limit", int'(refresh_warn_o), 0);
        drive(0, P_NOP, 0, 0);
        check("R10 over limit", int'(refresh_warn_o), 1);
        drive(1, P_NOP, 0, 0);
        check("R4 wake code", int'(cmd_o), 14);
        check("R4 wake state", int'(dev_state_o), 0);
        check("R4 wake ok", int'(viol_o), 0);
        check("R10 warn clears", int'(refresh_warn_o), 0);
        drive(0, P_DES, 0, 0);
        check("R2 pd by deselect", int'(dev_state_o), 1);
        drive(1, P_ACT, 0, 0);
        check("R4 wake with cmd", int'(viol_o), 1);
        check("R4 wake state 2", int'(dev_state_o), 0);
        drive(1, P_ACT, 0, 0);
        check("R9 bank not opened", int'(viol_o), 0);
        drive(1, P_PRE, 0, 13'h0400);
    endtask

    task automatic t_selfref;
        drive(0, P_REF, 0, 0);
        check("R2 sr code", int'(cmd_o), 4);
        check("R2 sr state", int'(dev_state_o), 2);
        for (int i = 0; i < 7; i++) drive(0, P_NOP, 0, 0);
        check("R10 no warn in sr", int'(refresh_warn_o), 0);
        check("R4 sr hold", int'(dev_state_o), 2);
        drive(1, P_MODE, 0, 0);
        check("R3 sr exit code", int'(cmd_o), 5);
        check("R3 sr exit state", int'(dev_state_o), 0);
        check("R3 sr exit ok", int'(viol_o), 0);
        check("R9 no mode load", int'(bl8_o), 0);
        drive(1, P_NOP, 0, 0);
    endtask

    task automatic t_bad_drop;
        drive(0, P_ACT, 4, 0);
        check("R2 bad drop code", int'(cmd_o), 16);
        check("R2 bad drop viol", int'(viol_o), 1);
        check("R2 bad drop state", int'(dev_state_o), 0);
        drive(0, P_NOP, 0, 0);
        check("R4 low hold", int'(cmd_o), 15);
        drive(1, P_RD, 4, 0);
        check("R4 active wake code", int'(cmd_o), 14);
        check("R4 active wake viol", int'(viol_o), 1);
        drive(1, P_RD, 4, 0);
        check("R9 drop left bank closed", int'(viol_o), 1);
        drive(1, P_NOP, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_decode();
        t_bank();
        t_burst();
        t_powerdown();
        t_selfref();
        t_bad_drop();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule